// File: doc/BRIEF.md
# Embedded Controller Message Link

This block is the message engine behind a byte-level I2C target port. An external embedded controller is the bus controller. It polls this block by reading from it and writing to it. The bit-level bus logic sits outside the block and presents it with byte events only: an address match with its direction, a received byte, a request for a byte to send, and a stop condition. The block keeps a small queue of outgoing messages from the local host. It pulls an active-low request line low to ask the controller to come and read.

On a controller read, the block serves the head message as a length byte followed by the payload. When the queue is empty, it answers with a fixed filler byte and queues a short no-op message. On a controller write, the block gathers the data bytes into a bounded receive buffer. At the stop it delivers the buffer as one message on a valid/ready port, provided the buffer holds at least two bytes.

Top module: `ec_msg_link`

## Requirements
- R1: Each queued message is sent on controller reads as one byte holding the payload count, then the payload bytes in host order; each read request yields exactly one `rdValid` pulse with the byte in the following cycle.
- R2: `reqN` goes low in the cycle after the host commits a message (`hostTxLast` accepted), and goes high after any byte is handed out on a read request, except as stated in R4.
- R3: A read request while no message is pending returns 0x8A and queues a no-op message whose payload is 0x07, 0x02 (framed as 0x02, 0x07, 0x02); `reqN` stays high after that byte.
- R4: Handing out the last byte of a message removes it from the queue; `reqN` is then low if another message is still pending and high otherwise.
- R5: Further read requests in the same read transaction after a message has finished return 0x01.
- R6: After a write-direction address event, data bytes are collected in arrival order starting at byte 0 of `rxMsg` (byte i at bits 8i+7:8i); the value on `busData` during the address event is never stored.
- R7: A receive message holds at most 32 bytes; further bytes are dropped and set the sticky `rxErr` flag, which only reset clears.
- R8: A stop ends a write transaction; the message is delivered on `rxValid` only if it holds two or more bytes, and a message of zero or one byte is discarded.
- R9: The transmit queue holds four messages in first-in first-out order; `hostTxReady` is low while four are pending, and bytes offered then are ignored.
- R10: After reset `reqN` is high, `rdValid`, `rxValid` and `rxErr` are low, and `hostTxReady` is high.
- R11: A delivered message keeps `rxValid`, `rxLen` and `rxMsg` unchanged until `rxReady`; a message completing while one is still held is dropped and sets `rxErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxValid | input | 1 | Host offers a payload byte |
| hostTxData | input | 8 | Host payload byte |
| hostTxLast | input | 1 | Offered byte ends the message |
| hostTxReady | output | 1 | Queue has a free slot |
| evAddr | input | 1 | Address matched (one-cycle pulse) |
| evAddrRead | input | 1 | Direction of the matched address, 1 = controller reads |
| evWrByte | input | 1 | Controller wrote a data byte on busData |
| evRdReq | input | 1 | Controller requests one byte |
| evStop | input | 1 | Stop condition seen |
| busData | input | 8 | Byte from the bus side |
| reqN | output | 1 | Active-low request for the controller to read |
| rdValid | output | 1 | Answer byte valid (one cycle) |
| rdData | output | 8 | Answer byte for the controller |
| rxValid | output | 1 | Received message available |
| rxReady | input | 1 | Consumer accepts the message |
| rxLen | output | 6 | Byte count of the received message |
| rxMsg | output | 256 | Received bytes, byte 0 in the low bits |
| rxErr | output | 1 | Sticky receive loss flag |

## Verification
Every payload length from 1 to 32 is sent through the queue with a length-dependent byte pattern. This separates a wrong length byte, a misplaced index and an off-by-one end of message. Separate sweeps cover reads on an empty queue, reads past the end of a message, and a full queue with a rejected extra offer. Together they separate filler bytes, no-op framing and first-in first-out order. Write transactions of 0 to 34 bytes separate the runt discard, exact delivery, and truncation with the error flag. A held undelivered message shows that a second completion does not overwrite it.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
  localparam int MSG_MAX   = 32;
  localparam int TXQ_DEPTH = 4;
  localparam int LEN_W     = $clog2(MSG_MAX + 1);
  localparam int IDX_W     = $clog2(MSG_MAX);
  localparam int PTR_W     = (TXQ_DEPTH > 1) ? $clog2(TXQ_DEPTH) : 1;
  localparam int CNT_W     = $clog2(TXQ_DEPTH + 1);

  localparam logic [7:0] BYTE_EMPTY = 8'h8A;
  localparam logic [7:0] BYTE_PAST  = 8'h01;
  localparam logic [7:0] NOOP_CMD   = 8'h07;
  localparam logic [7:0] NOOP_ARG   = 8'h02;
  localparam logic [LEN_W-1:0] NOOP_LEN = LEN_W'(2);

  typedef enum logic [1:0] {SEL_HEAD, SEL_NOOP, SEL_EMPTY, SEL_PAST} byteSel_e;
  typedef enum logic [1:0] {LINK_IDLE, LINK_RX, LINK_TX} linkState_e;

  typedef struct packed {
    logic             rdEn;
    byteSel_e         rdSel;
    logic [LEN_W-1:0] rdIdx;
    logic             txPop;
    logic             rxOpen;
    logic             rxAppend;
    logic             rxDeliver;
    logic             errSet;
  } ctlStrobe_t;

  typedef struct packed {
    logic [CNT_W-1:0] txCount;
    logic [LEN_W-1:0] headLen;
    logic [LEN_W-1:0] rxCnt;
    logic             outBusy;
    logic             hostCommit;
  } dpStatus_t;
endpackage

// File: rtl/ecl_ctrl.sv
module ecl_ctrl
  import ecl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evAddr,
  input  logic       evAddrRead,
  input  logic       evWrByte,
  input  logic       evRdReq,
  input  logic       evStop,
  input  dpStatus_t  st,
  output ctlStrobe_t cs,
  output logic       reqN
);
  linkState_e       state, stateNext;
  logic [LEN_W-1:0] txPos, txPosNext;
  logic             txDone, txDoneNext;
  logic             noopPending, noopNext;
  logic             reqNNext;
  logic [CNT_W:0]   pending;
  logic [LEN_W-1:0] curLen;

  assign pending = {1'b0, st.txCount} + (CNT_W+1)'(noopPending);
  assign curLen  = noopPending ? NOOP_LEN : st.headLen;

  always_comb begin
    cs         = '0;
    cs.rdSel   = SEL_HEAD;
    stateNext  = state;
    txPosNext  = txPos;
    txDoneNext = txDone;
    noopNext   = noopPending;
    reqNNext   = reqN;

    if (evStop) begin
      // a write transaction closes: keep the message only if it is not a runt
      if (state == LINK_RX && st.rxCnt > LEN_W'(1)) begin
        if (st.outBusy) cs.errSet    = 1'b1;
        else            cs.rxDeliver = 1'b1;
      end
      stateNext  = LINK_IDLE;
      txDoneNext = 1'b0;
    end else if (evAddr) begin
      if (evAddrRead) begin
        stateNext  = LINK_TX;
        txDoneNext = 1'b0;
      end else if (state != LINK_RX) begin
        stateNext = LINK_IDLE;
      end
    end else if (evWrByte) begin
      if (state == LINK_IDLE) begin
        cs.rxOpen = 1'b1;
        stateNext = LINK_RX;
      end else if (state == LINK_RX) begin
        if (st.rxCnt < LEN_W'(MSG_MAX)) cs.rxAppend = 1'b1;
        else                            cs.errSet   = 1'b1;
      end
    end else if (evRdReq) begin
      cs.rdEn  = 1'b1;
      reqNNext = 1'b1;
      if (txDone) begin
        cs.rdSel = SEL_PAST;
      end else if (pending == '0) begin
        cs.rdSel = SEL_EMPTY;
        noopNext = 1'b1;
      end else begin
        cs.rdSel = noopPending ? SEL_NOOP : SEL_HEAD;
        cs.rdIdx = txPos;
        if (txPos == curLen) begin
          if (noopPending) noopNext = 1'b0;
          else             cs.txPop = 1'b1;
          txPosNext  = '0;
          txDoneNext = 1'b1;
          reqNNext   = (pending <= (CNT_W+1)'(1));
        end else begin
          txPosNext = txPos + LEN_W'(1);
        end
      end
    end

    if (st.hostCommit) reqNNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= LINK_IDLE;
      txPos       <= '0;
      txDone      <= 1'b0;
      noopPending <= 1'b0;
      reqN        <= 1'b1;
    end else begin
      state       <= stateNext;
      txPos       <= txPosNext;
      txDone      <= txDoneNext;
      noopPending <= noopNext;
      reqN        <= reqNNext;
    end
  end
endmodule

// File: rtl/ecl_datapath.sv
module ecl_datapath
  import ecl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostTxValid,
  input  logic [7:0]           hostTxData,
  input  logic                 hostTxLast,
  output logic                 hostTxReady,
  input  logic [7:0]           busData,
  input  logic                 rxReady,
  input  ctlStrobe_t           cs,
  output dpStatus_t            st,
  output logic                 rdValid,
  output logic [7:0]           rdData,
  output logic                 rxValid,
  output logic [LEN_W-1:0]     rxLen,
  output logic [MSG_MAX*8-1:0] rxMsg,
  output logic                 rxErr
);
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     txCount;
  logic [LEN_W-1:0]     wrIdx, newLen;
  logic                 hostAccept, hostCommit;
  logic [MSG_MAX*8-1:0] slotData [TXQ_DEPTH];
  logic [LEN_W-1:0]     slotLen  [TXQ_DEPTH];
  logic [IDX_W-1:0]     byteSel;
  logic [7:0]           outByte;
  logic [MSG_MAX*8-1:0] asmBuf;
  logic [LEN_W-1:0]     rxCnt;

  assign hostTxReady = (txCount < CNT_W'(TXQ_DEPTH));
  assign hostAccept  = hostTxValid && hostTxReady;
  assign hostCommit  = hostAccept && hostTxLast;
  assign newLen      = (wrIdx < LEN_W'(MSG_MAX)) ? wrIdx + LEN_W'(1) : LEN_W'(MSG_MAX);

  // one storage slot per queue entry
  for (genvar g = 0; g < TXQ_DEPTH; g++) begin : gSlot
    logic [MSG_MAX*8-1:0] bytesQ;
    logic [LEN_W-1:0]     lenQ;
    logic                 hit;
    assign hit = hostAccept && (wrPtr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bytesQ <= '0;
        lenQ   <= '0;
      end else if (hit) begin
        if (wrIdx < LEN_W'(MSG_MAX))
          bytesQ[{wrIdx[IDX_W-1:0], 3'b000} +: 8] <= hostTxData;
        if (hostTxLast) lenQ <= newLen;
      end
    end
    assign slotData[g] = bytesQ;
    assign slotLen[g]  = lenQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wrIdx   <= '0;
      txCount <= '0;
    end else begin
      if (hostAccept) begin
        if (hostTxLast) begin
          wrIdx <= '0;
          wrPtr <= (wrPtr == PTR_W'(TXQ_DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
        end else if (wrIdx < LEN_W'(MSG_MAX)) begin
          wrIdx <= wrIdx + LEN_W'(1);
        end
      end
      if (cs.txPop)
        rdPtr <= (rdPtr == PTR_W'(TXQ_DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      case ({hostCommit, cs.txPop})
        2'b10:   txCount <= txCount + CNT_W'(1);
        2'b01:   txCount <= txCount - CNT_W'(1);
        default: txCount <= txCount;
      endcase
    end
  end

  // answer byte selection
  assign byteSel = IDX_W'(cs.rdIdx - LEN_W'(1));

  always_comb begin
    unique case (cs.rdSel)
      SEL_HEAD:  outByte = (cs.rdIdx == '0) ? 8'(slotLen[rdPtr])
                                            : slotData[rdPtr][{byteSel, 3'b000} +: 8];
      SEL_NOOP:  outByte = (cs.rdIdx == '0)          ? 8'(NOOP_LEN) :
                           (cs.rdIdx == LEN_W'(1))   ? NOOP_CMD : NOOP_ARG;
      SEL_EMPTY: outByte = BYTE_EMPTY;
      default:   outByte = BYTE_PAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= cs.rdEn;
      if (cs.rdEn) rdData <= outByte;
    end
  end

  // receive assembly and delivery
  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmBuf  <= '0;
      rxCnt   <= '0;
      rxValid <= 1'b0;
      rxLen   <= '0;
      rxMsg   <= '0;
      rxErr   <= 1'b0;
    end else begin
      if (cs.rxOpen) begin
        asmBuf <= {{(MSG_MAX*8-8){1'b0}}, busData};
        rxCnt  <= LEN_W'(1);
      end else if (cs.rxAppend) begin
        asmBuf[{rxCnt[IDX_W-1:0], 3'b000} +: 8] <= busData;
        rxCnt <= rxCnt + LEN_W'(1);
      end
      if (cs.rxDeliver) begin
        rxValid <= 1'b1;
        rxLen   <= rxCnt;
        rxMsg   <= asmBuf;
      end else if (rxReady) begin
        rxValid <= 1'b0;
      end
      if (cs.errSet) rxErr <= 1'b1;
    end
  end

  assign st.txCount    = txCount;
  assign st.headLen    = slotLen[rdPtr];
  assign st.rxCnt      = rxCnt;
  assign st.outBusy    = rxValid;
  assign st.hostCommit = hostCommit;
endmodule

// File: rtl/ec_msg_link.sv
module ec_msg_link
  import ecl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostTxValid,
  input  logic [7:0]           hostTxData,
  input  logic                 hostTxLast,
  output logic                 hostTxReady,
  input  logic                 evAddr,
  input  logic                 evAddrRead,
  input  logic                 evWrByte,
  input  logic                 evRdReq,
  input  logic                 evStop,
  input  logic [7:0]           busData,
  output logic                 reqN,
  output logic                 rdValid,
  output logic [7:0]           rdData,
  output logic                 rxValid,
  input  logic                 rxReady,
  output logic [LEN_W-1:0]     rxLen,
  output logic [MSG_MAX*8-1:0] rxMsg,
  output logic                 rxErr
);
  ctlStrobe_t cs;
  dpStatus_t  st;

  ecl_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .evAddr(evAddr), .evAddrRead(evAddrRead), .evWrByte(evWrByte),
    .evRdReq(evRdReq), .evStop(evStop),
    .st(st), .cs(cs), .reqN(reqN)
  );

  ecl_datapath uData (
    .clk(clk), .rstN(rstN),
    .hostTxValid(hostTxValid), .hostTxData(hostTxData), .hostTxLast(hostTxLast),
    .hostTxReady(hostTxReady), .busData(busData), .rxReady(rxReady),
    .cs(cs), .st(st), .rdValid(rdValid), .rdData(rdData),
    .rxValid(rxValid), .rxLen(rxLen), .rxMsg(rxMsg), .rxErr(rxErr)
  );
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker
  import ecl_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostTxValid,
  input logic                 hostTxLast,
  input logic                 hostTxReady,
  input logic                 evRdReq,
  input logic                 reqN,
  input logic                 rdValid,
  input logic                 rxValid,
  input logic                 rxReady,
  input logic [LEN_W-1:0]     rxLen,
  input logic [MSG_MAX*8-1:0] rxMsg,
  input logic                 rxErr
);
  AST_COMMIT_LOWERS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (hostTxValid && hostTxReady && hostTxLast) |=> !reqN);                     // R2
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    evRdReq |=> rdValid);                                                      // R1
  AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    !evRdReq |=> !rdValid);                                                    // R1
  AST_NO_RUNT_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (rxLen > LEN_W'(1) && rxLen <= LEN_W'(MSG_MAX)));              // R8
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxLen) && $stable(rxMsg)));  // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |=> rxErr);                                                          // R7
endmodule

bind ec_msg_link ecl_checker uChk (
  .clk(clk), .rstN(rstN), .hostTxValid(hostTxValid), .hostTxLast(hostTxLast),
  .hostTxReady(hostTxReady), .evRdReq(evRdReq), .reqN(reqN), .rdValid(rdValid),
  .rxValid(rxValid), .rxReady(rxReady), .rxLen(rxLen), .rxMsg(rxMsg), .rxErr(rxErr)
);

// File: tb/tb_ec_msg_link.sv
module tb_ec_msg_link;
  import ecl_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN, hostTxValid, hostTxLast, hostTxReady;
  logic [7:0] hostTxData, busData, rdData;
  logic evAddr, evAddrRead, evWrByte, evRdReq, evStop;
  logic reqN, rdValid, rxValid, rxReady, rxErr;
  logic [LEN_W-1:0] rxLen;
  logic [MSG_MAX*8-1:0] rxMsg;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  ec_msg_link dut (
    .clk(clk), .rstN(rstN), .hostTxValid(hostTxValid), .hostTxData(hostTxData),
    .hostTxLast(hostTxLast), .hostTxReady(hostTxReady), .evAddr(evAddr),
    .evAddrRead(evAddrRead), .evWrByte(evWrByte), .evRdReq(evRdReq), .evStop(evStop),
    .busData(busData), .reqN(reqN), .rdValid(rdValid), .rdData(rdData),
    .rxValid(rxValid), .rxReady(rxReady), .rxLen(rxLen), .rxMsg(rxMsg), .rxErr(rxErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int txByte(int seed, int i);
    return (seed * 29 + i * 11 + 3) & 8'hFF;
  endfunction

  function automatic int rxByte(int n, int i);
    return ((n * 5 + i * 3) ^ 8'h5A) & 8'hFF;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic addrEv(bit rd, logic [7:0] v);
    busData = v; evAddr = 1'b1; evAddrRead = rd;
    @(negedge clk);
    evAddr = 1'b0; evAddrRead = 1'b0;
  endtask

  task automatic wrEv(logic [7:0] v);
    busData = v; evWrByte = 1'b1;
    @(negedge clk);
    evWrByte = 1'b0;
  endtask

  task automatic stopEv();
    evStop = 1'b1;
    @(negedge clk);
    evStop = 1'b0;
  endtask

  task automatic readByte(output int b, output int r);
    evRdReq = 1'b1;
    @(negedge clk);
    evRdReq = 1'b0;
    chk("R1 rdValid", int'(rdValid), 1);
    b = int'(rdData);
    r = int'(reqN);
  endtask

  task automatic pushMsg(int len, int seed);
    for (int i = 0; i < len; i++) begin
      hostTxValid = 1'b1;
      hostTxData  = 8'(txByte(seed, i));
      hostTxLast  = (i == len - 1);
      @(negedge clk);
    end
    hostTxValid = 1'b0;
    hostTxLast  = 1'b0;
  endtask

  task automatic takeRx();
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  initial begin
    int b, r, expLen;
    rstN = 1'b0; hostTxValid = 1'b0; hostTxLast = 1'b0; hostTxData = '0;
    evAddr = 1'b0; evAddrRead = 1'b0; evWrByte = 1'b0; evRdReq = 1'b0;
    evStop = 1'b0; busData = '0; rxReady = 1'b0;
    @(negedge clk);
    doReset();

    // R10 reset state
    chk("R10 reqN", int'(reqN), 1);
    chk("R10 rdValid", int'(rdValid), 0);
    chk("R10 rxValid", int'(rxValid), 0);
    chk("R10 rxErr", int'(rxErr), 0);
    chk("R10 hostTxReady", int'(hostTxReady), 1);

    // R3 empty queue read, then the queued no-op
    addrEv(1'b1, 8'hA1);
    readByte(b, r);
    chk("R3 empty byte", b, 8'h8A);
    chk("R3 reqN after filler", r, 1);
    stopEv();
    addrEv(1'b1, 8'hA1);
    readByte(b, r); chk("R3 noop len", b, 8'h02);
    readByte(b, r); chk("R3 noop cmd", b, 8'h07);
    readByte(b, r); chk("R3 noop arg", b, 8'h02);
    chk("R4 reqN after noop", r, 1);
    readByte(b, r); chk("R5 past end after noop", b, 8'h01);
    stopEv();

    // R1 R2 R4 R5 sweep over every payload length
    for (int len = 1; len <= MSG_MAX; len++) begin
      pushMsg(len, len);
      chk("R2 reqN after commit", int'(reqN), 0);
      addrEv(1'b1, 8'hA1);
      for (int i = 0; i <= len; i++) begin
        readByte(b, r);
        chk("R1 framed byte", b, (i == 0) ? len : txByte(len, i - 1));
        chk("R2 reqN after byte", r, 1);
      end
      readByte(b, r);
      chk("R5 past end", b, 8'h01);
      stopEv();
    end

    // R9 full queue, rejected offer, FIFO order; R4 request re-armed
    for (int k = 0; k < TXQ_DEPTH; k++) pushMsg(k + 1, 100 + k);
    chk("R9 ready low when full", int'(hostTxReady), 0);
    hostTxValid = 1'b1; hostTxData = 8'hEE; hostTxLast = 1'b1;
    @(negedge clk);
    hostTxValid = 1'b0; hostTxLast = 1'b0;
    chk("R9 reqN unchanged by rejected offer", int'(reqN), 0);
    for (int k = 0; k < TXQ_DEPTH; k++) begin
      addrEv(1'b1, 8'hA1);
      for (int i = 0; i <= k + 1; i++) begin
        readByte(b, r);
        chk("R9 fifo byte", b, (i == 0) ? (k + 1) : txByte(100 + k, i - 1));
      end
      chk("R4 reqN after pop", r, (k < TXQ_DEPTH - 1) ? 0 : 1);
      stopEv();
      if (k == 0) chk("R9 ready after pop", int'(hostTxReady), 1);
    end
    addrEv(1'b1, 8'hA1);
    readByte(b, r);
    chk("R9 rejected offer not queued", b, 8'h8A);
    stopEv();
    addrEv(1'b1, 8'hA1);
    for (int i = 0; i < 3; i++) readByte(b, r);
    stopEv();

    // R11 held delivery
    addrEv(1'b0, 8'hA4);
    wrEv(8'h11); wrEv(8'h22);
    stopEv();
    chk("R11 first delivered", int'(rxValid), 1);
    chk("R11 first len", int'(rxLen), 2);
    addrEv(1'b0, 8'hA4);
    wrEv(8'h33); wrEv(8'h44); wrEv(8'h55);
    stopEv();
    chk("R11 still held", int'(rxValid), 1);
    chk("R11 len kept", int'(rxLen), 2);
    chk("R11 byte kept", int'(rxMsg[7:0]), 8'h11);
    chk("R11 loss flagged", int'(rxErr), 1);
    takeRx();
    chk("R11 released", int'(rxValid), 0);
    doReset();
    chk("R10 err cleared by reset", int'(rxErr), 0);

    // R6 R7 R8 receive length sweep
    for (int n = 0; n <= MSG_MAX + 2; n++) begin
      addrEv(1'b0, 8'hA5);
      for (int i = 0; i < n; i++) wrEv(8'(rxByte(n, i)));
      stopEv();
      expLen = (n > MSG_MAX) ? MSG_MAX : n;
      if (n > 1) begin
        chk("R8 delivered", int'(rxValid), 1);
        chk("R7 length", int'(rxLen), expLen);
        for (int i = 0; i < expLen; i++)
          chk("R6 byte order", int'(rxMsg[i*8 +: 8]), rxByte(n, i));
        takeRx();
      end else begin
        chk("R8 runt discarded", int'(rxValid), 0);
      end
      chk("R7 sticky error", int'(rxErr), (n > MSG_MAX) ? 1 : 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule